// File: doc/BRIEF.md
# Display Serial Video Line Scheduler

This block plans the link traffic for one video line of a display serial link host. A horizontal sync event from the pixel-timing side opens a line. The block then hands out packet descriptors one at a time. Each descriptor carries a type code and a length. A line starts with sync descriptors and continues with pixel packets, which may be split into chunks and padded with null packets. It ends with a tail slot that fills what is left of the programmed line time. The tail is either a low-power window or high-speed blanking. Line time is counted in lane byte clock cycles; for example, a 500 MHz clock lane gives an 8 ns byte clock.

A 2-bit mode field picks the transport. Burst mode sends the whole active line as one packet. Non-burst mode sends a configured number of fixed-size packets, using either sync pulses or sync events. The block requests low power for a blanking tail only when enough byte clocks remain to cover the cost of entering and leaving low power. The last line of a frame always ends in low power, and it can carry a peripheral-acknowledge request. After a last line, the block waits for the next vertical sync before it starts a new line. This is how its timing re-aligns once per frame.

Descriptors leave on a valid/ready handshake. If the consumer stalls, the line counter keeps running and a per-line underrun flag is raised.

Top module: `vid_line_sched`

## Requirements
- R1: While reset is held, and after it until the first line start, `descValid` and `underrun` are 0.
- R2: A line start is a `vsync` pulse, or an `hsync` pulse that is not being ignored. One cycle after it, the first descriptor is presented. For `cfgMode` 2'b00 the sync descriptors are sync-start (code 1) and then sync-end (code 2). For any other mode there is a single sync-event descriptor (code 3). All sync descriptors have length 0.
- R3: When `cfgMode[1]` is 1 (burst), exactly one pixel descriptor (code 4) follows the sync, with length `cfgActivePix`. The chunk-count and null-size settings have no effect.
- R4: In non-burst mode the block sends `cfgChunkCount` pixel descriptors (code 4), each of length `cfgPktSize`. A chunk count of 0 sends exactly one such descriptor.
- R5: In non-burst mode, when `cfgChunkCount` ≥ 1 and `cfgNullSize` ≠ 0, every pixel descriptor is followed by a null descriptor (code 5) of length `cfgNullSize`. Otherwise no null descriptor appears.
- R6: The line counter reads 0 in the first cycle after a line start and rises by one per cycle. The tail descriptor is presented right after the last pixel or null descriptor is accepted. Its length is `cfgLineTime` minus the counter value in that cycle. When this value is not positive, no tail is sent and the block idles.
- R7: On a line that is not last, the tail is low-power (code 7) if `cfgLpEn` is 1 and the tail length is ≥ `cfgLpOverhead`. Otherwise it is blanking (code 6).
- R8: On a line started with `lastLine` high, a tail that is sent is always low-power (code 7). `descAckReq` is 1 with that tail exactly when `cfgAckEn` is 1, and it is 0 with every other descriptor.
- R9: After a line starts with `lastLine` high, `hsync` pulses are ignored until a `vsync` pulse.
- R10: While `descValid` is 1 and `descReady` is 0, the same descriptor (type and length) stays presented in the next cycle.
- R11: `underrun` goes to 1 in the cycle after any cycle with `descValid` high and `descReady` low. It returns to 0 one cycle after a line start.
- R12: A line start in any state drops the rest of the current line and begins the new line's sync sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Lane byte clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgMode | input | 2 | Transport mode: 2'b00 pulses, 2'b01 events, 2'b1x burst |
| cfgActivePix | input | LEN_W | Active pixels per line (burst packet length) |
| cfgPktSize | input | LEN_W | Pixels per non-burst packet |
| cfgChunkCount | input | CHUNK_W | Packets per line in non-burst mode |
| cfgNullSize | input | LEN_W | Null packet length, 0 disables |
| cfgLineTime | input | LEN_W | Line period in byte clocks |
| cfgLpOverhead | input | LEN_W | Minimum tail length for a low-power window |
| cfgLpEn | input | 1 | Allow low power in the tail of ordinary lines |
| cfgAckEn | input | 1 | Request peripheral acknowledge at frame end |
| hsync | input | 1 | Line start event pulse |
| vsync | input | 1 | Frame start event pulse |
| lastLine | input | 1 | Marks the line being started as the last of its frame |
| descReady | input | 1 | Consumer accepts the presented descriptor |
| descValid | output | 1 | A descriptor is presented |
| descType | output | 3 | Descriptor type code |
| descLen | output | LEN_W | Descriptor length |
| descAckReq | output | 1 | Acknowledge request attached to the descriptor |
| underrun | output | 1 | Consumer stalled during the current line |

## Verification
The hardest case to reach is a tail that is suppressed. For that, the consumer must hold `descReady` low until the line counter has passed the programmed line time, so that no tail is sent at all while `underrun` stays set. The stimulus does this by holding ready low for more cycles than a short line lasts. A second case is a last line followed by an `hsync` that must be ignored. The stimulus issues that `hsync` on purpose and checks that the block stays idle until a later `vsync`. A behavioural queue model predicts every descriptor, including tail lengths under a periodic stall pattern, and the bench compares against it on every cycle.

// File: rtl/vls_pkg.sv
package vls_pkg;

  typedef enum logic [2:0] {
    D_NONE       = 3'd0,
    D_SYNC_START = 3'd1,
    D_SYNC_END   = 3'd2,
    D_SYNC_EVENT = 3'd3,
    D_PIXEL      = 3'd4,
    D_NULL       = 3'd5,
    D_BLANK      = 3'd6,
    D_LP         = 3'd7
  } descType_e;

  typedef enum logic [2:0] {
    S_IDLE, S_SYNC_A, S_SYNC_B, S_PIX, S_NUL, S_BLANK, S_LP
  } schedState_e;

  // control -> datapath strobes
  typedef struct packed {
    logic lineStart;
    logic pixAccept;
    logic loadTail;
    logic stall;
  } dpStrobe_t;

  // datapath -> control status
  typedef struct packed {
    logic lastChunk;
    logic allSent;
    logic remZero;
    logic lpFits;
    logic nullOn;
  } dpStatus_t;

endpackage

// File: rtl/vls_dpath.sv
module vls_dpath
  import vls_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int CHUNK_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  dpStrobe_t          strobe,
  input  descType_e          curType,
  input  logic               burst,
  input  logic [LEN_W-1:0]   cfgActivePix,
  input  logic [LEN_W-1:0]   cfgPktSize,
  input  logic [LEN_W-1:0]   cfgNullSize,
  input  logic [LEN_W-1:0]   cfgLineTime,
  input  logic [LEN_W-1:0]   cfgLpOverhead,
  input  logic [CHUNK_W-1:0] cfgChunkCount,
  output dpStatus_t          status,
  output logic [LEN_W-1:0]   descLen,
  output logic               underrun
);

  localparam logic [LEN_W-1:0]   CNT_MAX  = '1;
  localparam logic [CHUNK_W:0]   ONE_CHNK = (CHUNK_W+1)'(1);

  logic [LEN_W-1:0]   lineCnt;
  logic [LEN_W-1:0]   tailLen;
  logic [LEN_W-1:0]   remLen;
  logic [LEN_W:0]     cntNext;
  logic [CHUNK_W-1:0] chunkIdx;
  logic [CHUNK_W:0]   chunkTarget;
  logic [CHUNK_W:0]   idxPlusOne;

  // byte-clock line counter, restarted by every line start
  always_ff @(posedge clk) begin
    if (!rstN)                 lineCnt <= '0;
    else if (strobe.lineStart) lineCnt <= '0;
    else if (lineCnt != CNT_MAX) lineCnt <= lineCnt + 1'b1;
  end

  // remaining time as it will be seen in the next cycle
  always_comb begin
    cntNext        = {1'b0, lineCnt} + 1'b1;
    remLen         = cfgLineTime - cntNext[LEN_W-1:0];
    status.remZero = ({1'b0, cfgLineTime} <= cntNext);
    status.lpFits  = (remLen >= cfgLpOverhead);
    chunkTarget    = (burst || cfgChunkCount == '0) ? ONE_CHNK : {1'b0, cfgChunkCount};
    idxPlusOne     = {1'b0, chunkIdx} + 1'b1;
    status.lastChunk = (idxPlusOne >= chunkTarget);
    status.allSent   = ({1'b0, chunkIdx} >= chunkTarget);
    status.nullOn    = !burst && (cfgChunkCount != '0) && (cfgNullSize != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 chunkIdx <= '0;
    else if (strobe.lineStart) chunkIdx <= '0;
    else if (strobe.pixAccept) chunkIdx <= chunkIdx + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                tailLen <= '0;
    else if (strobe.loadTail) tailLen <= remLen;
  end

  always_ff @(posedge clk) begin
    if (!rstN)                 underrun <= 1'b0;
    else if (strobe.lineStart) underrun <= 1'b0;
    else if (strobe.stall)     underrun <= 1'b1;
  end

  always_comb begin
    unique case (curType)
      D_PIXEL:       descLen = burst ? cfgActivePix : cfgPktSize;
      D_NULL:        descLen = cfgNullSize;
      D_BLANK, D_LP: descLen = tailLen;
      default:       descLen = '0;
    endcase
  end

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.lineStart && lineCnt != CNT_MAX) |=> lineCnt == LEN_W'($past(lineCnt) + 1'b1)) // R6
    else $error("AST_CNT_STEP");
  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    strobe.lineStart |=> lineCnt == '0) // R6
    else $error("AST_CNT_RESTART");
  AST_UNDERRUN_SET: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stall && !strobe.lineStart) |=> underrun) // R11
    else $error("AST_UNDERRUN_SET");
  AST_UNDERRUN_CLR: assert property (@(posedge clk) disable iff (!rstN)
    strobe.lineStart |=> !underrun) // R11
    else $error("AST_UNDERRUN_CLR");

endmodule

// File: rtl/vls_ctrl.sv
module vls_ctrl
  import vls_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic [1:0] cfgMode,
  input  logic      cfgLpEn,
  input  logic      cfgAckEn,
  input  logic      hsync,
  input  logic      vsync,
  input  logic      lastLineIn,
  input  logic      descReady,
  input  dpStatus_t status,
  output dpStrobe_t strobe,
  output descType_e curType,
  output logic      descValid,
  output logic      descAckReq
);

  schedState_e stateQ, stateD, tailPick;
  logic lastLineQ, waitFrame, lineStart, accept;

  always_comb begin
    lineStart = vsync | (hsync & ~waitFrame);
    descValid = (stateQ != S_IDLE);
    accept    = descValid & descReady;

    unique case (stateQ)
      S_SYNC_A: curType = (cfgMode == 2'b00) ? D_SYNC_START : D_SYNC_EVENT;
      S_SYNC_B: curType = D_SYNC_END;
      S_PIX:    curType = D_PIXEL;
      S_NUL:    curType = D_NULL;
      S_BLANK:  curType = D_BLANK;
      S_LP:     curType = D_LP;
      default:  curType = D_NONE;
    endcase

    if (status.remZero)                            tailPick = S_IDLE;
    else if (lastLineQ || (cfgLpEn && status.lpFits)) tailPick = S_LP;
    else                                           tailPick = S_BLANK;

    stateD   = stateQ;
    strobe.loadTail = 1'b0;
    if (lineStart) begin
      stateD = S_SYNC_A;
    end else if (accept) begin
      unique case (stateQ)
        S_SYNC_A: stateD = (cfgMode == 2'b00) ? S_SYNC_B : S_PIX;
        S_SYNC_B: stateD = S_PIX;
        S_PIX: begin
          if (status.nullOn)         stateD = S_NUL;
          else if (status.lastChunk) begin stateD = tailPick; strobe.loadTail = 1'b1; end
          else                       stateD = S_PIX;
        end
        S_NUL: begin
          if (status.allSent) begin stateD = tailPick; strobe.loadTail = 1'b1; end
          else                stateD = S_PIX;
        end
        default: stateD = S_IDLE;
      endcase
    end

    strobe.lineStart = lineStart;
    strobe.pixAccept = accept && (stateQ == S_PIX) && !lineStart;
    strobe.stall     = descValid && !descReady;
    descAckReq       = (stateQ == S_LP) && lastLineQ && cfgAckEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ    <= S_IDLE;
      lastLineQ <= 1'b0;
      waitFrame <= 1'b0;
    end else begin
      stateQ <= stateD;
      if (lineStart) begin
        lastLineQ <= lastLineIn;
        waitFrame <= lastLineIn;
      end
    end
  end

  AST_ACK_ON_LP: assert property (@(posedge clk) disable iff (!rstN)
    descAckReq |-> (descValid && curType == D_LP)) // R8
    else $error("AST_ACK_ON_LP");
  AST_LAST_NO_BLANK: assert property (@(posedge clk) disable iff (!rstN)
    (descValid && lastLineQ) |-> curType != D_BLANK) // R8
    else $error("AST_LAST_NO_BLANK");
  AST_TYPE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.stall && !lineStart) |=> (descValid && $stable(curType))) // R10
    else $error("AST_TYPE_HOLD");
  AST_BURST_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == S_PIX && accept && cfgMode[1] && !lineStart) |=> stateQ != S_PIX) // R3
    else $error("AST_BURST_ONE");
  AST_HSYNC_GATED: assert property (@(posedge clk) disable iff (!rstN)
    (waitFrame && hsync && !vsync && stateQ == S_IDLE) |=> stateQ == S_IDLE) // R9
    else $error("AST_HSYNC_GATED");

endmodule

// File: rtl/vid_line_sched.sv
module vid_line_sched
  import vls_pkg::*;
#(
  parameter int LEN_W   = 16,
  parameter int CHUNK_W = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         cfgMode,
  input  logic [LEN_W-1:0]   cfgActivePix,
  input  logic [LEN_W-1:0]   cfgPktSize,
  input  logic [CHUNK_W-1:0] cfgChunkCount,
  input  logic [LEN_W-1:0]   cfgNullSize,
  input  logic [LEN_W-1:0]   cfgLineTime,
  input  logic [LEN_W-1:0]   cfgLpOverhead,
  input  logic               cfgLpEn,
  input  logic               cfgAckEn,
  input  logic               hsync,
  input  logic               vsync,
  input  logic               lastLine,
  input  logic               descReady,
  output logic               descValid,
  output logic [2:0]         descType,
  output logic [LEN_W-1:0]   descLen,
  output logic               descAckReq,
  output logic               underrun
);

  dpStrobe_t strobe;
  dpStatus_t status;
  descType_e curType;

  vls_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .cfgLpEn(cfgLpEn), .cfgAckEn(cfgAckEn),
    .hsync(hsync), .vsync(vsync), .lastLineIn(lastLine), .descReady(descReady),
    .status(status), .strobe(strobe), .curType(curType),
    .descValid(descValid), .descAckReq(descAckReq)
  );

  vls_dpath #(.LEN_W(LEN_W), .CHUNK_W(CHUNK_W)) uDpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .curType(curType), .burst(cfgMode[1]),
    .cfgActivePix(cfgActivePix), .cfgPktSize(cfgPktSize), .cfgNullSize(cfgNullSize),
    .cfgLineTime(cfgLineTime), .cfgLpOverhead(cfgLpOverhead), .cfgChunkCount(cfgChunkCount),
    .status(status), .descLen(descLen), .underrun(underrun)
  );

  assign descType = curType;

  AST_LEN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (descValid && !descReady && !strobe.lineStart) |=> $stable(descLen)) // R10
    else $error("AST_LEN_HOLD");
  AST_TAIL_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    (descValid && (descType == D_BLANK || descType == D_LP)) |-> descLen != '0) // R6
    else $error("AST_TAIL_NONZERO");

endmodule

// File: tb/tb_vid_line_sched.sv
module tb_vid_line_sched;
  localparam int CLK_PERIOD = 10;
  localparam int LEN_W      = 16;
  localparam int CHUNK_W    = 8;

  logic clk, rstN;
  logic [1:0] cfgMode;
  logic [LEN_W-1:0] cfgActivePix, cfgPktSize, cfgNullSize, cfgLineTime, cfgLpOverhead;
  logic [CHUNK_W-1:0] cfgChunkCount;
  logic cfgLpEn, cfgAckEn, hsync, vsync, lastLine, descReady;
  logic descValid, descAckReq, underrun;
  logic [2:0] descType;
  logic [LEN_W-1:0] descLen;

  vid_line_sched #(.LEN_W(LEN_W), .CHUNK_W(CHUNK_W)) dut (
    .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .cfgActivePix(cfgActivePix),
    .cfgPktSize(cfgPktSize), .cfgChunkCount(cfgChunkCount), .cfgNullSize(cfgNullSize),
    .cfgLineTime(cfgLineTime), .cfgLpOverhead(cfgLpOverhead), .cfgLpEn(cfgLpEn),
    .cfgAckEn(cfgAckEn), .hsync(hsync), .vsync(vsync), .lastLine(lastLine),
    .descReady(descReady), .descValid(descValid), .descType(descType), .descLen(descLen),
    .descAckReq(descAckReq), .underrun(underrun)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int failures = 0;

  task automatic check(bit ok, string tag, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  int    qT[$];
  int    qL[$];
  bit    qA[$];
  string qG[$];
  int    mCnt = 0;
  bit    tailPend = 0, mLast = 0, mWait = 0, mUnd = 0, expV = 0, prevStall = 0;
  bit    running = 0;
  string idleTag = "R1";

  always @(posedge clk) begin
    if (!rstN) begin
      qT.delete(); qL.delete(); qA.delete(); qG.delete();
      mCnt = 0; tailPend = 0; mLast = 0; mWait = 0; mUnd = 0; expV = 0; prevStall = 0;
      idleTag = "R1";
    end else begin : upd
      bit ls;
      bit aband;
      string sTag;
      ls = vsync || (hsync && !mWait);
      if (hsync && mWait && !vsync) idleTag = "R9";
      if (ls) begin
        aband = (qT.size() != 0) || tailPend;
        sTag  = aband ? "R12" : "R2";
        qT.delete(); qL.delete(); qA.delete(); qG.delete();
        if (cfgMode == 2'b00) begin
          qT.push_back(1); qL.push_back(0); qA.push_back(0); qG.push_back(sTag);
          qT.push_back(2); qL.push_back(0); qA.push_back(0); qG.push_back(sTag);
        end else begin
          qT.push_back(3); qL.push_back(0); qA.push_back(0); qG.push_back(sTag);
        end
        if (cfgMode[1]) begin
          qT.push_back(4); qL.push_back(int'(cfgActivePix)); qA.push_back(0); qG.push_back("R3");
        end else begin
          int n;
          n = (cfgChunkCount == 0) ? 1 : int'(cfgChunkCount);
          for (int i = 0; i < n; i++) begin
            qT.push_back(4); qL.push_back(int'(cfgPktSize)); qA.push_back(0); qG.push_back("R4");
            if (cfgChunkCount != 0 && cfgNullSize != 0) begin
              qT.push_back(5); qL.push_back(int'(cfgNullSize)); qA.push_back(0); qG.push_back("R5");
            end
          end
        end
        tailPend = 1; mLast = lastLine; mWait = lastLine; mCnt = 0; mUnd = 0;
        prevStall = 0; idleTag = "R6";
      end else begin
        prevStall = expV && !descReady;
        if (expV && descReady) begin
          void'(qT.pop_front()); void'(qL.pop_front());
          void'(qA.pop_front()); void'(qG.pop_front());
        end
        if (expV && !descReady) mUnd = 1;
        if (mCnt < 65535) mCnt++;
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && running) begin : cmp
      string tag;
      if (qT.size() == 0 && tailPend) begin
        int rem;
        tailPend = 0;
        rem = int'(cfgLineTime) - mCnt;
        if (rem > 0) begin
          bit isLp;
          isLp = mLast || (cfgLpEn && rem >= int'(cfgLpOverhead));
          qT.push_back(isLp ? 7 : 6);
          qL.push_back(rem);
          qA.push_back(isLp && mLast && cfgAckEn);
          qG.push_back(mLast ? "R8" : "R7");
        end
      end
      expV = (qT.size() != 0);
      if (expV) begin
        tag = prevStall ? "R10" : qG[0];
        check(descValid == 1'b1, tag, "valid", int'(descValid), 1);
        check(int'(descType) == qT[0], tag, "type", int'(descType), qT[0]);
        check(int'(descLen) == qL[0], tag, "len", int'(descLen), qL[0]);
        check(descAckReq == qA[0], (qT[0] == 7) ? "R8" : tag, "ack", int'(descAckReq), int'(qA[0]));
      end else begin
        check(descValid == 1'b0, idleTag, "valid", int'(descValid), 0);
      end
      check(underrun == mUnd, "R11", "underrun", int'(underrun), int'(mUnd));
    end
  end

  // ---------------- stimulus ----------------
  task automatic setCfg(int mode, int act, int pkt, int numc, int nul, int lt, int ovh,
                        bit lpEn, bit ackEn);
    @(negedge clk);
    cfgMode = 2'(mode); cfgActivePix = LEN_W'(act); cfgPktSize = LEN_W'(pkt);
    cfgChunkCount = CHUNK_W'(numc); cfgNullSize = LEN_W'(nul); cfgLineTime = LEN_W'(lt);
    cfgLpOverhead = LEN_W'(ovh); cfgLpEn = lpEn; cfgAckEn = ackEn;
  endtask

  task automatic line(bit isV, bit last, int n);
    @(negedge clk);
    if (isV) vsync = 1'b1; else hsync = 1'b1;
    lastLine = last;
    @(negedge clk);
    hsync = 1'b0; vsync = 1'b0; lastLine = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic stallLine(int n);
    @(negedge clk);
    hsync = 1'b1;
    @(negedge clk);
    hsync = 1'b0;
    for (int i = 0; i < n; i++) begin
      descReady = (i % 3) != 1;
      @(negedge clk);
    end
    descReady = 1'b1;
  endtask

  initial begin
    rstN = 1'b0; hsync = 0; vsync = 0; lastLine = 0; descReady = 1;
    cfgMode = 0; cfgActivePix = 0; cfgPktSize = 0; cfgChunkCount = 0; cfgNullSize = 0;
    cfgLineTime = 0; cfgLpOverhead = 0; cfgLpEn = 0; cfgAckEn = 0;
    repeat (3) @(negedge clk);
    check(descValid == 1'b0, "R1", "valid in reset", int'(descValid), 0);
    check(underrun == 1'b0, "R1", "underrun in reset", int'(underrun), 0);
    rstN = 1'b1;
    @(negedge clk);
    running = 1;
    repeat (4) @(negedge clk);

    // R2/R4/R5/R7: pulses, three chunks with nulls, LP tail
    setCfg(0, 0, 20, 3, 5, 60, 8, 1, 0);  line(0, 0, 65);
    // R2/R4: events, chunk count 0 -> one packet and no null
    setCfg(1, 0, 30, 0, 7, 50, 8, 1, 0);  line(0, 0, 55);
    // R5/R7: one chunk plus null, LP disabled -> blanking
    setCfg(1, 0, 12, 1, 4, 40, 8, 0, 0);  line(0, 0, 45);
    // R5/R7: null size 0, overhead too large -> blanking
    setCfg(0, 0, 10, 2, 0, 30, 40, 1, 0); line(0, 0, 35);
    // R3: burst modes ignore chunks and nulls
    setCfg(2, 100, 10, 4, 9, 30, 5, 1, 0); line(0, 0, 35);
    setCfg(3, 64, 10, 4, 9, 30, 5, 1, 0);  line(0, 0, 35);
    // R6: line time shorter than the packets -> no tail
    setCfg(0, 0, 8, 3, 5, 3, 2, 1, 0);    line(0, 0, 12);
    // R10/R11: periodic stall
    setCfg(0, 0, 20, 2, 3, 60, 8, 1, 0);  stallLine(65);
    // R11 clears at next line start
    line(0, 0, 65);
    // R12: restart mid-line
    line(0, 0, 3); line(0, 0, 65);
    // R6/R11: stall past the line end -> tail suppressed
    setCfg(1, 0, 5, 1, 0, 20, 2, 1, 0);
    @(negedge clk); hsync = 1'b1; @(negedge clk); hsync = 1'b0; descReady = 1'b0;
    repeat (25) @(negedge clk);
    descReady = 1'b1;
    repeat (10) @(negedge clk);
    // R8/R9: last line with ack, ignored hsync, vsync restart
    setCfg(1, 0, 16, 2, 2, 40, 60, 0, 1); line(0, 1, 45);
    line(0, 0, 10);
    line(1, 0, 45);
    // R8: last line without ack, then vsync as last line, then vsync normal
    setCfg(0, 0, 16, 1, 0, 40, 2, 1, 0);  line(0, 1, 45);
    line(1, 1, 45);
    line(0, 0, 8);
    line(1, 0, 45);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL R6 watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule